// File: doc/BRIEF.md
# Oversampled GCR Telemetry Reply Receiver

This block receives the short telemetry reply that a motor controller sends back on the same wire once a bidirectional command frame has ended. A strobe arms it. It then waits a programmable turnaround time, takes four level samples per telemetry bit over a 32-bit window, and turns the lengths of the constant-level runs into a bit stream. It undoes the transition coding of that stream, maps four 5-bit GCR groups back to nibbles, checks the nibble checksum, and reports a 12-bit payload together with the period it encodes, stored as a 3-bit exponent and a 9-bit mantissa.

Each armed capture gives exactly one result: a single-cycle `valid_o` pulse with the payload and the period, or a single-cycle `error_o` pulse. The turnaround delay and the sample spacing are run-time counts in clock cycles. This lets the same logic follow any command bit rate: the spacing is normally three quarters of the command bit time divided by four, so a telemetry bit is 4/3 as fast as a command bit. Control of the line direction is done elsewhere.

Top module: `gcr_telemetry_rx`

## Requirements
- R1: After reset, `valid_o` and `error_o` are 0, and `payload_o` and `rot_period_o` are 0.
- R2: A `start_i` accepted while idle waits `turn_dly_i` cycles and then takes one line sample every `samp_per_i` cycles, 4 per bit for 32 bits (128 samples). Each accepted start yields exactly one single-cycle pulse, on `valid_o` or on `error_o`.
- R3: At each level change, the finished run of N samples adds bits equal to the previous level: 3 bits when N >= 10, 2 bits when 6 <= N < 10, 1 bit otherwise. The level before the first change of a capture counts as idle and adds no bits.
- R4: With 21 bits collected, one 1 is appended. With 20 bits collected, two 1s are appended. Otherwise the last 21 bits are used as they are.
- R5: The 21-bit code c becomes g = c XOR (c >> 1). Group k is g[5k+4:5k], so group 0 is the lowest. The GCR symbols for nibbles 0..F are 11001, 11011, 10010, 10011, 11101, 10101, 10110, 10111, 11010, 01001, 01010, 01011, 11110, 01101, 01110, 01111. Any other symbol is invalid.
- R6: The nibble from group 0 is the checksum. It must equal the 4-bit inverse of the XOR of the nibbles from groups 1, 2 and 3.
- R7: `payload_o` = {nibble3, nibble2, nibble1}. `rot_period_o` = payload[8:0] shifted left by payload[11:9], 16 bits wide.
- R8: An invalid symbol in any group, or a checksum mismatch, gives an `error_o` pulse with `valid_o` low, and sets `payload_o` and `rot_period_o` to 0.
- R9: A capture window in which the line never changes level gives an `error_o` pulse.
- R10: A `start_i` that arrives while a capture is running is ignored. The running capture completes with the result it would have had anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Line level (idle high) |
| start_i | input | 1 | Arm a capture, honoured only while idle |
| turn_dly_i | input | CNT_W | Turnaround delay in clock cycles |
| samp_per_i | input | CNT_W | Clock cycles between line samples |
| payload_o | output | 12 | Decoded 12-bit payload |
| rot_period_o | output | 16 | Period value mantissa << exponent |
| valid_o | output | 1 | One-cycle pulse: reply decoded correctly |
| error_o | output | 1 | One-cycle pulse: reply rejected |

## Verification
The bench builds the block with its default parameters: 16-bit counts, 4 samples per bit and a 32-bit window. It drives two run-time timings, a 20-cycle turnaround with 4-cycle spacing and a 37-cycle turnaround with 5-cycle spacing, so each reply takes only a few hundred cycles and many replies fit in one run. The bench chooses payloads whose checksum symbols end the frame with a one-bit or a two-bit final high run, so both padding paths of R4 are exercised. Bad checksums, an invalid symbol, a silent line and a start that arrives in mid-capture cover the rejection and ignore paths.

// File: rtl/gcr_rx_pkg.sv
package gcr_rx_pkg;
  localparam int PAY_W    = 12;
  localparam int MANT_W   = 9;
  localparam int EXP_W    = 3;
  localparam int PER_W    = MANT_W + (1 << EXP_W) - 1;
  localparam int NGRP     = 4;
  localparam int GRP_BITS = 5 * NGRP;
  localparam int CODE_W   = GRP_BITS + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SAMP} tmr_state_e;

  typedef struct packed {
    logic       ok;
    logic [3:0] nib;
  } sym_dec_t;

  // 5-bit GCR symbol to nibble; ok is low for the sixteen unused symbols
  function automatic sym_dec_t gcr_lookup(input logic [4:0] sym);
    sym_dec_t r;
    r = '{ok: 1'b1, nib: 4'h0};
    case (sym)
      5'h19: r.nib = 4'h0;
      5'h1B: r.nib = 4'h1;
      5'h12: r.nib = 4'h2;
      5'h13: r.nib = 4'h3;
      5'h1D: r.nib = 4'h4;
      5'h15: r.nib = 4'h5;
      5'h16: r.nib = 4'h6;
      5'h17: r.nib = 4'h7;
      5'h1A: r.nib = 4'h8;
      5'h09: r.nib = 4'h9;
      5'h0A: r.nib = 4'hA;
      5'h0B: r.nib = 4'hB;
      5'h1E: r.nib = 4'hC;
      5'h0D: r.nib = 4'hD;
      5'h0E: r.nib = 4'hE;
      5'h0F: r.nib = 4'hF;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gcr_rx_timer.sv
module gcr_rx_timer
  import gcr_rx_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSAMP = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] turn_dly_i,
  input  logic [CNT_W-1:0] samp_per_i,
  output logic             arm_o,
  output logic             samp_o,
  output logic             last_o
);
  localparam int SC_W = $clog2(NSAMP);

  tmr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [SC_W-1:0]  scnt;

  assign arm_o  = start_i && (state == ST_IDLE);
  assign samp_o = (state == ST_SAMP) &&
                  (({1'b0, cnt} + 1'b1) >= {1'b0, samp_per_i});
  assign last_o = samp_o && (scnt == SC_W'(NSAMP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      scnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: if (cnt >= turn_dly_i) begin
          state <= ST_SAMP;
          cnt   <= '0;
          scnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (samp_o) begin
          cnt  <= '0;
          scnt <= scnt + 1'b1;
          if (last_o) state <= ST_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R2: the last sample of a window is itself a sample strobe
  a_r2_last_is_sample: assert property (@(posedge clk) disable iff (rst)
    last_o |-> samp_o);
  // R2: strobes are spaced by the sample period
  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    (samp_o && !last_o && samp_per_i > 1) |=> !samp_o);
  // R10: no new arming while a capture runs
  a_r10_no_rearm: assert property (@(posedge clk) disable iff (rst)
    (samp_o && !last_o) |=> !arm_o);
endmodule

// File: rtl/gcr_rx_runs.sv
module gcr_rx_runs
  import gcr_rx_pkg::*;
#(
  parameter int SPB   = 4,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              samp_i,
  input  logic              last_i,
  input  logic              line_i,
  output logic [CODE_W-1:0] code_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              seen_o,
  output logic              done_o
);
  localparam int RUN_MAX = 3 * SPB;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int TH3     = 3 * SPB - 2;
  localparam int TH2     = 2 * SPB - 2;

  logic             prev;
  logic [RUN_W-1:0] run;
  logic [1:0]       nbits;
  logic             edge_s;

  assign edge_s = samp_i && (line_i != prev);

  always_comb begin
    if (run >= RUN_W'(TH3))      nbits = 2'd3;
    else if (run >= RUN_W'(TH2)) nbits = 2'd2;
    else                         nbits = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b1;
      run    <= '0;
      code_o <= '0;
      len_o  <= '0;
      seen_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= samp_i && last_i;
      if (clr_i) begin
        prev   <= 1'b1;
        run    <= '0;
        code_o <= '0;
        len_o  <= '0;
        seen_o <= 1'b0;
      end else if (edge_s) begin
        if (seen_o) begin
          case (nbits)
            2'd3:    code_o <= {code_o[CODE_W-4:0], {3{prev}}};
            2'd2:    code_o <= {code_o[CODE_W-3:0], {2{prev}}};
            default: code_o <= {code_o[CODE_W-2:0], prev};
          endcase
          len_o <= len_o + LEN_W'(nbits);
        end
        seen_o <= 1'b1;
        prev   <= line_i;
        run    <= RUN_W'(1);
      end else if (samp_i && run != RUN_W'(RUN_MAX)) begin
        run <= run + 1'b1;
      end
    end
  end

  // R3: every counted run adds one to three bits
  a_r3_len_step: assert property (@(posedge clk) disable iff (rst)
    (edge_s && seen_o && !clr_i) |=>
      ((len_o - $past(len_o)) >= LEN_W'(1) && (len_o - $past(len_o)) <= LEN_W'(3)));
  // R3: the idle level before the first change adds nothing
  a_r3_idle_uncounted: assert property (@(posedge clk) disable iff (rst)
    (!seen_o && !clr_i) |=> (len_o == '0));
endmodule

// File: rtl/gcr_rx_decode.sv
module gcr_rx_decode
  import gcr_rx_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              seen_i,
  output logic [PAY_W-1:0]  payload_o,
  output logic [PER_W-1:0]  rot_period_o,
  output logic              valid_o,
  output logic              error_o
);
  logic [CODE_W-1:0]   padded;
  logic [GRP_BITS-1:0] xored;
  sym_dec_t            dec [NGRP];
  logic [NGRP-1:0]     sym_ok;
  logic                chk_ok, good;
  logic [PAY_W-1:0]    pay_c;
  logic [PER_W-1:0]    per_c;

  always_comb begin
    if (len_i == LEN_W'(CODE_W))          padded = {code_i[CODE_W-2:0], 1'b1};
    else if (len_i == LEN_W'(CODE_W - 1)) padded = {code_i[CODE_W-3:0], 2'b11};
    else                                  padded = code_i;
  end

  assign xored = padded[GRP_BITS-1:0] ^ padded[GRP_BITS:1];

  for (genvar g = 0; g < NGRP; g++) begin : g_sym
    assign dec[g]    = gcr_lookup(xored[5*g +: 5]);
    assign sym_ok[g] = dec[g].ok;
  end

  assign chk_ok = (dec[0].nib == ~(dec[1].nib ^ dec[2].nib ^ dec[3].nib));
  assign good   = seen_i && (&sym_ok) && chk_ok;
  assign pay_c  = {dec[3].nib, dec[2].nib, dec[1].nib};
  assign per_c  = PER_W'(pay_c[MANT_W-1:0]) << pay_c[PAY_W-1 -: EXP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      payload_o    <= '0;
      rot_period_o <= '0;
      valid_o      <= 1'b0;
      error_o      <= 1'b0;
    end else begin
      valid_o <= done_i && good;
      error_o <= done_i && !good;
      if (done_i) begin
        payload_o    <= good ? pay_c : '0;
        rot_period_o <= good ? per_c : '0;
      end
    end
  end

  // R8: never both verdicts at once
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && error_o));
  // R8: a rejected reply carries zeroed data
  a_r8_error_zero: assert property (@(posedge clk) disable iff (rst)
    error_o |-> (payload_o == '0 && rot_period_o == '0));
  // R2: a verdict only follows the end of a capture window
  a_r2_after_window: assert property (@(posedge clk) disable iff (rst)
    (valid_o || error_o) |-> $past(done_i));
endmodule

// File: rtl/gcr_telemetry_rx.sv
module gcr_telemetry_rx
  import gcr_rx_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SPB   = 4,
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] turn_dly_i,
  input  logic [CNT_W-1:0] samp_per_i,
  output logic [11:0]      payload_o,
  output logic [15:0]      rot_period_o,
  output logic             valid_o,
  output logic             error_o
);
  localparam int NSAMP = SPB * NBITS;
  localparam int LEN_W = $clog2(NSAMP + 1);

  logic              line_q, arm, samp, last, done, seen;
  logic [CODE_W-1:0] code;
  logic [LEN_W-1:0]  len;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= line_i;
  end

  gcr_rx_timer #(.CNT_W(CNT_W), .NSAMP(NSAMP)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .turn_dly_i(turn_dly_i),
    .samp_per_i(samp_per_i), .arm_o(arm), .samp_o(samp), .last_o(last));

  gcr_rx_runs #(.SPB(SPB), .LEN_W(LEN_W)) u_runs (
    .clk(clk), .rst(rst), .clr_i(arm), .samp_i(samp), .last_i(last),
    .line_i(line_q), .code_o(code), .len_o(len), .seen_o(seen), .done_o(done));

  gcr_rx_decode #(.LEN_W(LEN_W)) u_dec (
    .clk(clk), .rst(rst), .done_i(done), .code_i(code), .len_i(len),
    .seen_i(seen), .payload_o(payload_o), .rot_period_o(rot_period_o),
    .valid_o(valid_o), .error_o(error_o));
endmodule

// File: tb/gcr_telemetry_rx_tb_top.sv
module gcr_telemetry_rx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_i = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] turn_dly_i = 16'd20;
  logic [15:0] samp_per_i = 16'd4;
  logic [11:0] payload_o;
  logic [15:0] rot_period_o;
  logic        valid_o, error_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcr_telemetry_rx dut_i (
    .clk(clk), .rst(rst), .line_i(line_i), .start_i(start_i),
    .turn_dly_i(turn_dly_i), .samp_per_i(samp_per_i), .payload_o(payload_o),
    .rot_period_o(rot_period_o), .valid_o(valid_o), .error_o(error_o));

  typedef struct {
    bit          err;
    logic [11:0] pay;
    logic [15:0] per;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, n_push = 0, n_seen = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'h19;  4'h1: return 5'h1B;  4'h2: return 5'h12;  4'h3: return 5'h13;
      4'h4: return 5'h1D;  4'h5: return 5'h15;  4'h6: return 5'h16;  4'h7: return 5'h17;
      4'h8: return 5'h1A;  4'h9: return 5'h09;  4'hA: return 5'h0A;  4'hB: return 5'h0B;
      4'hC: return 5'h1E;  4'hD: return 5'h0D;  4'hE: return 5'h0E;  default: return 5'h0F;
    endcase
  endfunction

  // mode: 0 good, 1 bad checksum, 2 invalid symbol, 3 silent line
  task automatic send_reply(input logic [11:0] pay, input int mode, input int dly,
                            input int per, input bit restart, input string tag);
    logic [3:0]  ck;
    logic [19:0] g;
    logic [21:0] c;
    exp_t        e;
    ck = ~(pay[3:0] ^ pay[7:4] ^ pay[11:8]);
    if (mode == 1) ck = ck ^ 4'h1;
    g = {enc(pay[11:8]), enc(pay[7:4]), enc(pay[3:0]), enc(ck)};
    if (mode == 2) g[14:10] = 5'h1F;
    c[0] = 1'b1;
    for (int i = 0; i < 20; i++) c[i+1] = c[i] ^ g[i];
    c[21] = 1'b0;
    e.err = (mode != 0);
    e.pay = (mode == 0) ? pay : 12'h000;
    e.per = (mode == 0) ? (16'(pay[8:0]) << pay[11:9]) : 16'h0000;
    e.tag = tag;
    q.push_back(e);
    n_push++;
    turn_dly_i = 16'(dly);
    samp_per_i = 16'(per);
    line_i = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (dly + 2*per) @(negedge clk);
    if (mode != 3) begin
      for (int i = 21; i >= 0; i--) begin
        line_i = c[i];
        for (int j = 0; j < 4*per; j++) begin
          start_i = restart && (i == 11) && (j == 0);
          @(negedge clk);
        end
      end
    end
    start_i = 1'b0;
    line_i = 1'b1;
    while (n_seen < n_push) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && (valid_o || error_o)) begin
      exp_t e;
      n_seen++;
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected result", 1, 0);
      end else begin
        e = q.pop_front();
        check(error_o == e.err && valid_o == !e.err, {e.tag, " verdict"}, error_o, e.err);
        check(payload_o == e.pay, {e.tag, " payload"}, payload_o, e.pay);
        check(rot_period_o == e.per, {e.tag, " period"}, rot_period_o, e.per);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", n_seen, n_push);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(valid_o == 1'b0 && error_o == 1'b0, "R1 flags", {valid_o, error_o}, 0);
    check(payload_o == 12'h000, "R1 payload", payload_o, 0);
    check(rot_period_o == 16'h0000, "R1 period", rot_period_o, 0);
    repeat (40) @(negedge clk);
    check(n_seen == 0, "R2 no result without start", n_seen, 0);

    // good replies; checksum symbols give one-bit (R4 pad one) or two-bit (R4 pad two) tails
    send_reply(12'h000, 0, 20, 4, 1'b0, "R5 R7 R4 pad-one zero");
    send_reply(12'hFFF, 0, 20, 4, 1'b0, "R6 R7 R4 pad-one max exponent");
    send_reply(12'h001, 0, 20, 4, 1'b0, "R3 R7 R4 pad-two");
    send_reply(12'hA5C, 0, 20, 4, 1'b0, "R5 R6 R4 pad-two");
    send_reply(12'h3F7, 0, 37, 5, 1'b0, "R2 R7 slower sampling");
    send_reply(12'h6B2, 0, 37, 5, 1'b0, "R2 R5 slower sampling");
    // rejections
    send_reply(12'h123, 1, 20, 4, 1'b0, "R8 R6 checksum mismatch");
    send_reply(12'h9D4, 2, 20, 4, 1'b0, "R8 R5 invalid symbol");
    send_reply(12'h555, 3, 20, 4, 1'b0, "R9 silent line");
    // start during capture is ignored
    send_reply(12'h47E, 0, 20, 4, 1'b1, "R10 mid-capture start");
    repeat (700) @(negedge clk);
    check(n_seen == n_push, "R10 R2 one result per accepted start", n_seen, n_push);
    check(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
    send_reply(12'hC0D, 0, 20, 4, 1'b0, "R2 R10 recovery after ignored start");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule